// File: doc/BRIEF.md
# Parallel Bus Arbitration Unit

This block runs one device's bid for ownership of a shared 8-bit parallel SCSI-style bus. All bus lines are modelled as active-high wired-OR values. The unit watches the busy, select and reset lines and the data lines. When a request is pending and the bus has stayed free long enough, it drives busy together with the single data line that matches its own ID. It then waits out the arbitration window and inspects the data lines. If it holds the highest ID present, it drives select and keeps every driven line steady through a settle window. Otherwise it withdraws.

Every delay is a nanosecond parameter. At elaboration each one becomes a cycle count for the clock frequency parameter. Minimum delays are rounded up and maximum delays are rounded down. With the defaults (125 MHz, ID 3) these counts are: 13 cycles of continuous bus-free before driving, 213 cycles of arbitration window, and 113 cycles of settle hold after the win. The unit reports won, lost and busy flags. A lost round is retried automatically at the next bus-free for as long as the request stays high. Bus reset drops every driven line at once.

Top module: `scsi_arbiter`

## Requirements
- R1: While rst_n is low and just after it rises, bsy_out, sel_out, id_out, won, lost and busy are all 0.
- R2: bsy_out rises only after busy, select and bus reset have all been low for FREE_CYC consecutive sampled edges in a row. FREE_CYC is 13 at the defaults: the larger of the rounded-up bus-free delay and deskew delay, and never more than the rounded-down bus-set delay (137). Any interruption restarts the count.
- R3: The only data line the unit ever drives is bit MY_ID (value 8'h08 at defaults). It drives that line exactly while bsy_out is high, and it drives no parity.
- R4: The data lines are judged exactly ARB_CYC clock edges after bsy_out rises. ARB_CYC is 213 at the defaults, the rounded-up 1.7 us. No win is declared earlier.
- R5: If no data bit above MY_ID is set at the judging edge, sel_out and won rise together while bsy_out and id_out stay driven. Set bits below MY_ID have no effect. Bit 7 is highest.
- R6: After a win, bsy_out, sel_out and id_out stay unchanged for at least HOLD_CYC cycles (113, the rounded-up 900 ns), even if the request drops. They are released on the edge that finds the request low and the hold done.
- R7: Select seen from another device while arbitrating releases bsy_out and id_out on the next edge, well inside the 81-cycle bus-clear limit. lost is then high for one cycle.
- R8: A data bit above MY_ID seen at the judging edge releases bsy_out and id_out on the next edge. lost is then high for one cycle.
- R9: Bus reset sampled high releases all driven lines on the next edge without raising lost. The unit then waits for bus-free again if the request is still high, and goes idle otherwise.
- R10: The request is taken only in idle. Dropping it while waiting for bus-free returns to idle (busy low). After a loss with the request still high, the unit stays off the bus until the next bus-free and then arbitrates again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| arb_req | input | 1 | Request to win the bus, held level |
| bsy_in | input | 1 | Wired-OR busy line as seen on the bus |
| sel_in | input | 1 | Wired-OR select line as seen on the bus |
| rst_in | input | 1 | Bus reset line |
| db_in | input | BUS_W | Wired-OR data lines as seen on the bus |
| bsy_out | output | 1 | This unit drives busy |
| sel_out | output | 1 | This unit drives select |
| id_out | output | BUS_W | Data lines driven by this unit |
| won | output | 1 | Arbitration won, select driven |
| lost | output | 1 | One-cycle pulse on losing a round |
| busy | output | 1 | Unit is not idle |

## Verification
The bench attacks the timing edges first. A bus-free gap of ten cycles must not start a bid; a detector that ignored the stability window would drive busy early. The entry delay must be exactly 13 edges and the judging edge exactly 213 edges after busy; an off-by-one in a counter or a truncated conversion shows up as a shifted latency in the scoreboard. The priority compare is tested with a higher bit, which must lose, and with a lower bit, which must still win; a compare that treated any foreign bit as higher, or reversed the order, fails one of the two. Foreign select, bus reset during the window and bus reset during the settle hold are each injected. A unit that kept driving, pulsed lost on reset, or released early during the 113-cycle hold is reported.

// File: rtl/scsi_arb_pkg.sv
package scsi_arb_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_ARB,
    ST_WON,
    ST_LOST
  } arb_state_t;

  // minimum delay: round the cycle count up
  function automatic int cyc_min(input int ns, input int mhz);
    return (ns * mhz + 999) / 1000;
  endfunction

  // maximum delay: round the cycle count down
  function automatic int cyc_max(input int ns, input int mhz);
    return (ns * mhz) / 1000;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/arb_cycle_counter.sv
module arb_cycle_counter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         en,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (clr)              cnt <= '0;
    else if (en && cnt != '1)  cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/arb_free_detect.sv
module arb_free_detect #(
  parameter int W        = 8,
  parameter int FREE_CYC = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic bsy,
  input  logic sel,
  input  logic brst,
  output logic free_now,
  output logic free_reached
);
  localparam logic [W-1:0] FREE_LAST = W'(FREE_CYC - 1);

  logic [W-1:0] run_cnt;

  assign free_now = !bsy && !sel && !brst;

  // counts consecutive free edges only while the unit waits
  arb_cycle_counter #(.W(W)) u_run (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!active || !free_now),
    .en   (1'b1),
    .cnt  (run_cnt)
  );

  assign free_reached = free_now && (run_cnt >= FREE_LAST);
endmodule

// File: rtl/arb_prio_check.sv
module arb_prio_check #(
  parameter int BUS_W = 8,
  parameter int MY_ID = 3
) (
  input  logic [BUS_W-1:0] db,
  output logic             higher
);
  logic [BUS_W-1:0] hi_bits;

  for (genvar i = 0; i < BUS_W; i++) begin : g_bit
    localparam bit TAKE = (i > MY_ID);
    assign hi_bits[i] = db[i] & TAKE;
  end

  assign higher = |hi_bits;
endmodule

// File: rtl/scsi_arbiter.sv
module scsi_arbiter
  import scsi_arb_pkg::*;
#(
  parameter int CLK_MHZ   = 125,
  parameter int BUS_W     = 8,
  parameter int MY_ID     = 3,
  parameter int DESKEW_NS = 45,
  parameter int FREE_NS   = 100,
  parameter int ARB_NS    = 1700,
  parameter int SETTLE_NS = 450
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arb_req,
  input  logic             bsy_in,
  input  logic             sel_in,
  input  logic             rst_in,
  input  logic [BUS_W-1:0] db_in,
  output logic             bsy_out,
  output logic             sel_out,
  output logic [BUS_W-1:0] id_out,
  output logic             won,
  output logic             lost,
  output logic             busy
);
  localparam int FREE_CYC = imax(cyc_min(FREE_NS, CLK_MHZ), cyc_min(DESKEW_NS, CLK_MHZ));
  localparam int ARB_CYC  = cyc_min(ARB_NS, CLK_MHZ);
  localparam int HOLD_CYC = cyc_min(2 * SETTLE_NS, CLK_MHZ);
  localparam int CNT_W    = $clog2(imax(FREE_CYC, imax(ARB_CYC, HOLD_CYC)) + 1) + 1;
  localparam logic [CNT_W-1:0] ARB_LAST  = CNT_W'(ARB_CYC - 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(HOLD_CYC - 1);
  localparam logic [BUS_W-1:0] OWN_MASK  = {{(BUS_W-1){1'b0}}, 1'b1} << MY_ID;

  arb_state_t       state, nxt;
  logic [CNT_W-1:0] arb_cnt, hold_cnt;

  // named internal events
  logic bus_free_now, free_reached, arb_expired, higher_seen, hold_done;

  arb_free_detect #(.W(CNT_W), .FREE_CYC(FREE_CYC)) u_free (
    .clk         (clk),
    .rst_n       (rst_n),
    .active      (state == ST_WAIT),
    .bsy         (bsy_in),
    .sel         (sel_in),
    .brst        (rst_in),
    .free_now    (bus_free_now),
    .free_reached(free_reached)
  );

  arb_cycle_counter #(.W(CNT_W)) u_arb_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state != ST_ARB),
    .en   (1'b1),
    .cnt  (arb_cnt)
  );

  arb_cycle_counter #(.W(CNT_W)) u_hold_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state != ST_WON),
    .en   (1'b1),
    .cnt  (hold_cnt)
  );

  arb_prio_check #(.BUS_W(BUS_W), .MY_ID(MY_ID)) u_prio (
    .db    (db_in),
    .higher(higher_seen)
  );

  assign arb_expired = (state == ST_ARB) && (arb_cnt == ARB_LAST);
  assign hold_done   = (hold_cnt >= HOLD_LAST);

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (arb_req) nxt = ST_WAIT;
      ST_WAIT: begin
        if (!arb_req)          nxt = ST_IDLE;
        else if (free_reached) nxt = ST_ARB;
      end
      ST_ARB: begin
        if (rst_in)           nxt = arb_req ? ST_WAIT : ST_IDLE;
        else if (sel_in)      nxt = ST_LOST;
        else if (arb_expired) nxt = higher_seen ? ST_LOST : ST_WON;
      end
      ST_WON: begin
        if (rst_in)                     nxt = arb_req ? ST_WAIT : ST_IDLE;
        else if (!arb_req && hold_done) nxt = ST_IDLE;
      end
      ST_LOST: nxt = arb_req ? ST_WAIT : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign bsy_out = (state == ST_ARB) || (state == ST_WON);
  assign sel_out = (state == ST_WON);
  assign id_out  = bsy_out ? OWN_MASK : '0;
  assign won     = (state == ST_WON);
  assign lost    = (state == ST_LOST);
  assign busy    = (state != ST_IDLE);

  AST_DRIVE_AFTER_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bsy_out) |-> $past(!bsy_in && !sel_in && !rst_in)); // R2
  AST_SEL_ON_JUDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sel_out) |-> $past(arb_expired && !higher_seen)); // R4
  AST_WIN_KEEPS_ID: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(won) |-> (bsy_out && id_out == OWN_MASK)); // R5
  AST_HOLD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_WON && !hold_done && !rst_in) |=>
      ($stable(bsy_out) && $stable(sel_out) && $stable(id_out))); // R6
  AST_YIELD_TO_SEL: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_ARB && sel_in && !rst_in) |=> (!bsy_out && lost)); // R7
  AST_HIGHER_LOSES: assert property (@(posedge clk) disable iff (!rst_n)
    (arb_expired && higher_seen && !sel_in && !rst_in) |=> (lost && id_out == '0)); // R8
  AST_BUS_RESET_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_in |=> (!bsy_out && !sel_out && id_out == '0 && !lost)); // R9
  AST_ONE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({won, lost})); // R10

endmodule

// File: tb/scsi_arbiter_test.sv
module scsi_arbiter_test;
  // bench-side timing: 8 ns period, ceil(ns/8) for minimums, floor for maximums
  function automatic int up8(input int ns);   return (ns + 7) / 8; endfunction
  function automatic int down8(input int ns); return ns / 8;       endfunction

  localparam int T_FREE  = (up8(100) > up8(45)) ? up8(100) : up8(45);
  localparam int T_SET   = down8(1100);
  localparam int T_ARB   = up8(1700);
  localparam int T_HOLD  = up8(900);
  localparam int T_CLEAR = down8(650);
  localparam logic [7:0] OWN = 8'h08;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, arb_req, rst_in;
  logic       oth_bsy, oth_sel;
  logic [7:0] oth_db;
  logic       bsy_out, sel_out, won, lost, busy;
  logic [7:0] id_out;
  logic       bus_bsy, bus_sel;
  logic [7:0] bus_db;

  assign bus_bsy = bsy_out | oth_bsy;
  assign bus_sel = sel_out | oth_sel;
  assign bus_db  = id_out | oth_db;

  scsi_arbiter uut (
    .clk(clk), .rst_n(rst_n), .arb_req(arb_req),
    .bsy_in(bus_bsy), .sel_in(bus_sel), .rst_in(rst_in), .db_in(bus_db),
    .bsy_out(bsy_out), .sel_out(sel_out), .id_out(id_out),
    .won(won), .lost(lost), .busy(busy)
  );

  int total = 0;
  int bad   = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard: kind 1 = win, 2 = loss; lat = edges since bsy_out rose
  typedef struct { int kind; int lat; } exp_t;
  exp_t q[$];

  task automatic expect_outcome(input int kind, input int lat);
    exp_t e;
    e.kind = kind;
    e.lat  = lat;
    q.push_back(e);
  endtask

  int   since_bsy = 0;
  logic prev_bsy = 1'b0, prev_won = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bsy_out && !prev_bsy) since_bsy = 0;
      else since_bsy++;
      if ((won && !prev_won) || lost) begin
        int k;
        exp_t e;
        k = won ? 1 : 2;
        if (q.size() == 0) chk(1'b0, "R5 R8 unexpected outcome", k, 0);
        else begin
          e = q.pop_front();
          chk(e.kind == k, "R5 R8 outcome kind", k, e.kind);
          chk(e.lat == since_bsy, "R4 outcome latency", since_bsy, e.lat);
        end
      end
      prev_bsy = bsy_out;
      prev_won = won;
    end
  end

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wait_drive(output int n);
    n = 0;
    while (!bsy_out && n < 400) begin step(); n++; end
  endtask

  task automatic wait_sel(output int n, output bit early);
    n = 0; early = 1'b0;
    while (!sel_out && n < 400) begin
      if (won) early = 1'b1;
      step(); n++;
    end
  endtask

  initial begin
    int n;
    bit early, rose;
    rst_n = 1'b0; arb_req = 1'b0; rst_in = 1'b0;
    oth_bsy = 1'b0; oth_sel = 1'b0; oth_db = 8'h00;
    repeat (3) @(negedge clk);
    chk({bsy_out, sel_out, id_out, won, lost, busy} == '0, "R1 in reset", id_out, 0);
    rst_n = 1'b1;
    step();
    chk({bsy_out, sel_out, id_out, won, lost, busy} == '0, "R1 after reset", busy, 0);

    // R10: request held while bus busy, then dropped while waiting
    oth_bsy = 1'b1; arb_req = 1'b1;
    repeat (5) step();
    chk(busy && !bsy_out, "R10 waits off bus", bsy_out, 0);
    arb_req = 1'b0;
    step();
    chk(!busy, "R10 drop while waiting", busy, 0);
    arb_req = 1'b1;
    repeat (3) step();

    // R2: free gap shorter than FREE window must not start a bid
    oth_bsy = 1'b0; rose = 1'b0;
    repeat (10) begin step(); if (bsy_out) rose = 1'b1; end
    oth_bsy = 1'b1;
    repeat (3) begin step(); if (bsy_out) rose = 1'b1; end
    chk(!rose, "R2 short free gap", rose, 0);

    // R2 R3 R4 R5 R6: clean win
    expect_outcome(1, T_ARB);
    oth_bsy = 1'b0;
    wait_drive(n);
    chk(n == T_FREE, "R2 entry delay", n, T_FREE);
    chk(n <= T_SET, "R2 within set limit", n, T_SET);
    chk(id_out == OWN, "R3 own id only", id_out, OWN);
    wait_sel(n, early);
    chk(n == T_ARB, "R4 judge edge", n, T_ARB);
    chk(!early, "R4 no early win", early, 0);
    chk(won && bsy_out && id_out == OWN, "R5 win keeps drive", id_out, OWN);
    arb_req = 1'b0; n = 0;
    while (sel_out && n < 400) begin step(); n++; end
    chk(n == T_HOLD, "R6 settle hold", n, T_HOLD);
    chk(!busy && !bsy_out && id_out == 8'h00, "R6 released", id_out, 0);

    // R8: higher ID loses; R10 retry; R5 lower ID ignored
    arb_req = 1'b1;
    expect_outcome(2, T_ARB);
    wait_drive(n);
    oth_bsy = 1'b1; oth_db = 8'h20;
    n = 0;
    while (!lost && n < 400) begin step(); n++; end
    chk(n == T_ARB, "R8 loss at judge edge", n, T_ARB);
    chk(!bsy_out && id_out == 8'h00, "R8 released", id_out, 0);
    oth_sel = 1'b1;
    repeat (20) step();
    chk(busy && !bsy_out, "R10 stays off after loss", bsy_out, 0);
    oth_bsy = 1'b0; oth_sel = 1'b0; oth_db = 8'h00;
    expect_outcome(1, T_ARB);
    wait_drive(n);
    chk(n == T_FREE, "R10 retry at next free", n, T_FREE);
    oth_bsy = 1'b1; oth_db = 8'h02;
    wait_sel(n, early);
    chk(n == T_ARB && won, "R5 lower id ignored", n, T_ARB);
    arb_req = 1'b0;
    while (sel_out) step();
    oth_bsy = 1'b0; oth_db = 8'h00;
    step();

    // R7: foreign select during window
    arb_req = 1'b1;
    wait_drive(n);
    repeat (50) @(negedge clk);
    expect_outcome(2, 51);
    oth_sel = 1'b1; oth_bsy = 1'b1;
    step();
    chk(!bsy_out && id_out == 8'h00 && lost, "R7 yield to select", bsy_out, 0);
    chk(1 <= T_CLEAR, "R7 clear limit", 1, T_CLEAR);
    arb_req = 1'b0;
    repeat (2) step();
    chk(!busy && !lost, "R7 single pulse then idle", lost, 0);
    oth_sel = 1'b0; oth_bsy = 1'b0;
    step();

    // R9: bus reset during window and during hold
    arb_req = 1'b1;
    wait_drive(n);
    repeat (30) step();
    rst_in = 1'b1;
    step();
    chk(!bsy_out && id_out == 8'h00 && !lost && busy, "R9 reset in window", bsy_out, 0);
    repeat (5) step();
    rst_in = 1'b0;
    expect_outcome(1, T_ARB);
    wait_drive(n);
    chk(n == T_FREE, "R9 rebid after reset", n, T_FREE);
    wait_sel(n, early);
    repeat (20) step();
    rst_in = 1'b1;
    step();
    chk(!sel_out && !bsy_out && !won && !lost, "R9 reset in hold", sel_out, 0);
    arb_req = 1'b0;
    step();
    rst_in = 1'b0;
    step();
    chk(!busy, "R9 idle after reset", busy, 0);

    chk(q.size() == 0, "R5 all outcomes seen", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog R1 actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule